// File: doc/BRIEF.md
# System Register Access Checker

This block holds a single 128-bit system register. For every access request it decides, in the same cycle, what the access does. It can read or write the register, raise an undefined-instruction outcome, trap to the hypervisor level (2) or to the monitor level (3), send the access to a fixed memory slot, or pass it on to the separate level-2 register. Each request gives the instruction encoding, the access width (64 or 128 bits), a read/write flag, write data and the current privilege level. Hypervisor and monitor controls arrive as plain inputs.

The checks form a strict priority chain, and the chain differs by privilege level, by accessor (primary or alias) and by width. A 64-bit access reaches only the lower half of the store. Exception entry, memory traffic and the level-2 register are handled outside the block. The block only reports the outcome, the syndrome class, the memory offset and the read data.

Top module: `sysreg_guard`

## Requirements
- R1: `req_enc` packs {op0[1:0], op1[2:0], CRn[3:0], CRm[3:0], op2[2:0]} from bit 15 down. 0xC100 is the primary accessor and 0xE900 is the alias accessor (op1 = 0b101). Any other encoding gives the undefined outcome.
- R2: Any request at privilege level 0 gives the undefined outcome, for either accessor and either width.
- R3: `out_code` is one-hot while `req_valid` is high: bit0 undefined, bit1 trap to level 2, bit2 trap to level 3, bit3 memory redirect, bit4 level-2 register redirect, bit5 register access. It is zero when no request is present.
- R4: A 64-bit primary access at level 1 is checked in this order. First, level 2 enabled with the virtual-memory trap bit set traps to level 2; reads use `vm_trap_rd` and writes use `vm_trap_wr`. Next, level 2 enabled, fine-grained traps present, level 3 absent or `fg_allow` set, and the matching fine-grained bit set traps to level 2. Next, `nv_mode` equal to 0b111 gives a memory redirect. Otherwise the access reaches the register.
- R5: A 128-bit primary access at level 1 uses the gate "level 3 present and `el3_wide_en` = 0". With the gate open and `undef_first` set, it is undefined before any other check. After the fine-grained check, level 2 enabled with `xctl_en` = 0 or `xctl_wide_en` = 0 traps to level 2. After that, an open gate gives undefined if `sdd_undef` is set and a level-3 trap otherwise. The remaining checks follow R4.
- R6: A primary access at level 2 goes to the level-2 register when `el2_host` is set and reaches this register otherwise. At level 2 a 128-bit access first applies the R5 gate checks (undefined-first, then undefined or level-3 trap). At level 3 it always reaches this register.
- R7: An alias access at level 1 depends only on `nv_mode`. 0b101 gives a memory redirect. Any other value with bit 0 set traps to level 2. All remaining values give undefined.
- R8: At level 3 an alias access reaches the register only when `el2_host` is set, and is undefined otherwise. Level 2 applies the same host rule. For a 128-bit alias access at level 2, the R5 undefined-first check comes before the host check and the R5 gate trap comes after it.
- R9: `out_class` is 0x18 for a trap by a 64-bit access and 0x14 for a trap by a 128-bit access. It is 0 for all other outcomes.
- R10: `mem_off` is 0x200 on a memory redirect and 0 otherwise.
- R11: On a register-access read, a 64-bit read returns bits [63:0] zero-extended and a 128-bit read returns all 128 bits. `rd_data` is zero for any other outcome.
- R12: The store resets to zero. A register-access write of 64 bits replaces bits [63:0] and keeps bits [127:64]. A 128-bit write replaces all bits. Requests with any other outcome leave the store unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_enc | input | 16 | Packed instruction encoding |
| req_el | input | 2 | Current privilege level 0..3 |
| req_wide | input | 1 | 1 = 128-bit access, 0 = 64-bit |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 128 | Write data (lower 64 bits used by 64-bit writes) |
| el2_en | input | 1 | Level 2 enabled |
| el2_host | input | 1 | Level-2 host mode active |
| el3_present | input | 1 | Level 3 implemented |
| vm_trap_rd | input | 1 | Virtual-memory read trap |
| vm_trap_wr | input | 1 | Virtual-memory write trap |
| fg_present | input | 1 | Fine-grained traps implemented |
| fg_allow | input | 1 | Level 3 allows fine-grained traps |
| fg_trap_rd | input | 1 | Fine-grained read trap |
| fg_trap_wr | input | 1 | Fine-grained write trap |
| nv_mode | input | 3 | Nested-virtualization field |
| xctl_en | input | 1 | Extended hypervisor control enabled |
| xctl_wide_en | input | 1 | Extended control 128-bit enable |
| el3_wide_en | input | 1 | Level-3 128-bit enable |
| undef_first | input | 1 | Undefined takes priority when gated |
| sdd_undef | input | 1 | Gated 128-bit access is undefined instead of trapping |
| out_code | output | 6 | One-hot outcome |
| out_class | output | 6 | Syndrome class on traps |
| mem_off | output | 12 | Memory redirect offset |
| rd_data | output | 128 | Read data |

## Verification
The bound checker checks, on every cycle, the properties that hold whatever the controls are. It checks the one-hot outcome, undefined at level 0 and for unknown encodings, the pairing of trap class with width, and the redirect offset. It also checks the store: lower-half-only updates for 64-bit writes, full replacement for 128-bit writes, and no change on any other outcome. The priority order among competing traps, the nested-virtualization decode for the alias, and the host-mode routing depend on combinations of many controls. Only the bench shows those: it compares every random and directed request against an independent outcome model and a shadow copy of the register.

// File: rtl/sysreg_guard_pkg.sv
package sysreg_guard_pkg;
    localparam int DW   = 128;
    localparam int HW   = DW / 2;
    localparam int ENCW = 16;
    localparam int OFFW = 12;
    localparam int CLSW = 6;
    localparam int NVW  = 3;

    localparam logic [ENCW-1:0] ENC_PRIMARY = 16'hC100;
    localparam logic [ENCW-1:0] ENC_ALIAS   = 16'hE900;
    localparam logic [OFFW-1:0] MEM_SLOT    = 12'h200;
    localparam logic [CLSW-1:0] CLS_NARROW  = 6'h18;
    localparam logic [CLSW-1:0] CLS_WIDE    = 6'h14;
    localparam logic [NVW-1:0]  NV_MEM_ALL  = 3'b111;
    localparam logic [NVW-1:0]  NV_MEM_ALT  = 3'b101;

    typedef enum logic [5:0] {
        OUT_NONE  = 6'b000000,
        OUT_UNDEF = 6'b000001,
        OUT_TRAP2 = 6'b000010,
        OUT_TRAP3 = 6'b000100,
        OUT_MEM   = 6'b001000,
        OUT_L2REG = 6'b010000,
        OUT_REG   = 6'b100000
    } outcome_e;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_PRIMARY,
        ACC_ALIAS
    } acc_kind_e;

    typedef struct packed {
        logic           el2_en;
        logic           host;
        logic           el3_present;
        logic           vm_rd;
        logic           vm_wr;
        logic           fg_present;
        logic           fg_allow;
        logic           fg_rd;
        logic           fg_wr;
        logic [NVW-1:0] nv;
        logic           xctl_en;
        logic           xctl_wide;
        logic           el3_wide;
        logic           undef_first;
        logic           sdd_undef;
    } ctl_t;

    function automatic acc_kind_e classify(input logic [ENCW-1:0] enc);
        if (enc == ENC_PRIMARY)    return ACC_PRIMARY;
        else if (enc == ENC_ALIAS) return ACC_ALIAS;
        else                       return ACC_NONE;
    endfunction
endpackage

// File: rtl/sysreg_decode.sv
module sysreg_decode
    import sysreg_guard_pkg::*;
(
    input  logic [ENCW-1:0] enc,
    output acc_kind_e       kind
);
    always_comb kind = classify(enc);
endmodule

// File: rtl/sysreg_policy.sv
module sysreg_policy
    import sysreg_guard_pkg::*;
(
    input  logic      valid,
    input  acc_kind_e kind,
    input  logic [1:0] el,
    input  logic      wide,
    input  logic      write,
    input  ctl_t      ctl,
    output outcome_e  code
);
    logic wide_gate;
    logic vm_hit;
    logic fg_hit;
    logic xctl_hit;
    logic gate_undef_first;
    outcome_e gate_result;

    always_comb begin
        wide_gate        = wide && ctl.el3_present && !ctl.el3_wide;
        gate_undef_first = wide_gate && ctl.undef_first;
        gate_result      = ctl.sdd_undef ? OUT_UNDEF : OUT_TRAP3;
        vm_hit           = ctl.el2_en && (write ? ctl.vm_wr : ctl.vm_rd);
        fg_hit           = ctl.el2_en && ctl.fg_present &&
                           (!ctl.el3_present || ctl.fg_allow) &&
                           (write ? ctl.fg_wr : ctl.fg_rd);
        xctl_hit         = wide && ctl.el2_en && (!ctl.xctl_en || !ctl.xctl_wide);
    end

    always_comb begin
        code = OUT_NONE;
        if (!valid) begin
            code = OUT_NONE;
        end else if (kind == ACC_NONE || el == 2'd0) begin
            code = OUT_UNDEF;
        end else if (kind == ACC_PRIMARY) begin
            unique case (el)
                2'd1: begin
                    if (gate_undef_first)          code = OUT_UNDEF;
                    else if (vm_hit)               code = OUT_TRAP2;
                    else if (fg_hit)               code = OUT_TRAP2;
                    else if (xctl_hit)             code = OUT_TRAP2;
                    else if (wide_gate)            code = gate_result;
                    else if (ctl.nv == NV_MEM_ALL) code = OUT_MEM;
                    else                           code = OUT_REG;
                end
                2'd2: begin
                    if (gate_undef_first)          code = OUT_UNDEF;
                    else if (wide_gate)            code = gate_result;
                    else if (ctl.host)             code = OUT_L2REG;
                    else                           code = OUT_REG;
                end
                default:                           code = OUT_REG;
            endcase
        end else begin
            unique case (el)
                2'd1: begin
                    if (ctl.nv == NV_MEM_ALT)      code = OUT_MEM;
                    else if (ctl.nv[0])            code = OUT_TRAP2;
                    else                           code = OUT_UNDEF;
                end
                2'd2: begin
                    if (gate_undef_first)          code = OUT_UNDEF;
                    else if (!ctl.host)            code = OUT_UNDEF;
                    else if (wide_gate)            code = gate_result;
                    else                           code = OUT_REG;
                end
                default:                           code = ctl.host ? OUT_REG : OUT_UNDEF;
            endcase
        end
    end
endmodule

// File: rtl/sysreg_store.sv
module sysreg_store
    import sysreg_guard_pkg::*;
#(
    parameter int WIDTH = DW,
    parameter int PARTS = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PARTS-1:0] part_we,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] q
);
    localparam int PW = WIDTH / PARTS;

    for (genvar g = 0; g < PARTS; g++) begin : g_part
        logic [PW-1:0] part_q;
        always_ff @(posedge clk) begin
            if (rst)             part_q <= '0;
            else if (part_we[g]) part_q <= wdata[g*PW +: PW];
        end
        assign q[g*PW +: PW] = part_q;
    end
endmodule

// File: rtl/sysreg_guard.sv
module sysreg_guard
    import sysreg_guard_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    input  logic [ENCW-1:0] req_enc,
    input  logic [1:0]      req_el,
    input  logic            req_wide,
    input  logic            req_write,
    input  logic [DW-1:0]   req_wdata,
    input  logic            el2_en,
    input  logic            el2_host,
    input  logic            el3_present,
    input  logic            vm_trap_rd,
    input  logic            vm_trap_wr,
    input  logic            fg_present,
    input  logic            fg_allow,
    input  logic            fg_trap_rd,
    input  logic            fg_trap_wr,
    input  logic [NVW-1:0]  nv_mode,
    input  logic            xctl_en,
    input  logic            xctl_wide_en,
    input  logic            el3_wide_en,
    input  logic            undef_first,
    input  logic            sdd_undef,
    output logic [5:0]      out_code,
    output logic [CLSW-1:0] out_class,
    output logic [OFFW-1:0] mem_off,
    output logic [DW-1:0]   rd_data
);
    acc_kind_e     kind;
    outcome_e      code;
    ctl_t          ctl;
    logic [1:0]    part_we;
    logic [DW-1:0] store_q;
    logic          reg_hit;

    assign ctl = '{el2_en: el2_en, host: el2_host, el3_present: el3_present,
                   vm_rd: vm_trap_rd, vm_wr: vm_trap_wr,
                   fg_present: fg_present, fg_allow: fg_allow,
                   fg_rd: fg_trap_rd, fg_wr: fg_trap_wr, nv: nv_mode,
                   xctl_en: xctl_en, xctl_wide: xctl_wide_en,
                   el3_wide: el3_wide_en, undef_first: undef_first,
                   sdd_undef: sdd_undef};

    sysreg_decode u_decode (.enc(req_enc), .kind(kind));

    sysreg_policy u_policy (
        .valid(req_valid), .kind(kind), .el(req_el), .wide(req_wide),
        .write(req_write), .ctl(ctl), .code(code)
    );

    assign reg_hit = (code == OUT_REG);
    assign part_we = {reg_hit && req_write && req_wide, reg_hit && req_write};

    sysreg_store #(.WIDTH(DW), .PARTS(2)) u_store (
        .clk(clk), .rst(rst), .part_we(part_we), .wdata(req_wdata), .q(store_q)
    );

    always_comb begin
        out_code  = code;
        out_class = '0;
        if (code == OUT_TRAP2 || code == OUT_TRAP3)
            out_class = req_wide ? CLS_WIDE : CLS_NARROW;
        mem_off = (code == OUT_MEM) ? MEM_SLOT : '0;
        rd_data = '0;
        if (reg_hit && !req_write)
            rd_data = req_wide ? store_q : {{HW{1'b0}}, store_q[HW-1:0]};
    end
endmodule

// File: rtl/sysreg_guard_chk.sv
module sysreg_guard_chk
    import sysreg_guard_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            req_valid,
    input logic [ENCW-1:0] req_enc,
    input logic [1:0]      req_el,
    input logic            req_wide,
    input logic            req_write,
    input logic [DW-1:0]   req_wdata,
    input logic [5:0]      out_code,
    input logic [CLSW-1:0] out_class,
    input logic [OFFW-1:0] mem_off,
    input logic [DW-1:0]   store_q
);
    logic is_trap;
    logic reg_wr;
    assign is_trap = out_code[1] || out_code[2];
    assign reg_wr  = req_valid && req_write && out_code[5];

    // R1
    bad_enc_undef_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_enc != ENC_PRIMARY && req_enc != ENC_ALIAS |-> out_code == 6'b000001);

    // R2
    el0_undef_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_el == 2'd0 |-> out_code == 6'b000001);

    // R3
    code_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> $countones(out_code) == 1);

    // R3
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> out_code == 6'b0);

    // R9
    trap_class_chk: assert property (@(posedge clk) disable iff (rst)
        is_trap |-> out_class == (req_wide ? CLS_WIDE : CLS_NARROW));

    // R9
    no_trap_class_chk: assert property (@(posedge clk) disable iff (rst)
        !is_trap |-> out_class == '0);

    // R10
    mem_off_chk: assert property (@(posedge clk) disable iff (rst)
        mem_off == (out_code[3] ? MEM_SLOT : '0));

    // R12
    narrow_write_chk: assert property (@(posedge clk) disable iff (rst)
        reg_wr && !req_wide |=> store_q[DW-1:HW] == $past(store_q[DW-1:HW]) &&
                               store_q[HW-1:0] == $past(req_wdata[HW-1:0]));

    // R12
    wide_write_chk: assert property (@(posedge clk) disable iff (rst)
        reg_wr && req_wide |=> store_q == $past(req_wdata));

    // R12
    store_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !reg_wr |=> $stable(store_q));
endmodule

bind sysreg_guard sysreg_guard_chk u_chk (.*);

// File: tb/sysreg_guard_bench.sv
module sysreg_guard_bench;
    import sysreg_guard_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic            req_valid = 1'b0;
    logic [ENCW-1:0] req_enc = '0;
    logic [1:0]      req_el = '0;
    logic            req_wide = 1'b0, req_write = 1'b0;
    logic [DW-1:0]   req_wdata = '0;
    ctl_t            c = '0;
    logic [5:0]      out_code;
    logic [CLSW-1:0] out_class;
    logic [OFFW-1:0] mem_off;
    logic [DW-1:0]   rd_data;

    sysreg_guard u_sysreg_guard (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_enc(req_enc),
        .req_el(req_el), .req_wide(req_wide), .req_write(req_write),
        .req_wdata(req_wdata), .el2_en(c.el2_en), .el2_host(c.host),
        .el3_present(c.el3_present), .vm_trap_rd(c.vm_rd), .vm_trap_wr(c.vm_wr),
        .fg_present(c.fg_present), .fg_allow(c.fg_allow), .fg_trap_rd(c.fg_rd),
        .fg_trap_wr(c.fg_wr), .nv_mode(c.nv), .xctl_en(c.xctl_en),
        .xctl_wide_en(c.xctl_wide), .el3_wide_en(c.el3_wide),
        .undef_first(c.undef_first), .sdd_undef(c.sdd_undef),
        .out_code(out_code), .out_class(out_class), .mem_off(mem_off),
        .rd_data(rd_data)
    );

    int errors = 0;
    int checks = 0;
    logic [DW-1:0] shadow = '0;
    bit done = 0;

    task automatic check(input string tag, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Expected outcome as bit index: 0 undef,1 trap2,2 trap3,3 mem,4 l2reg,5 reg
    function automatic int model(input logic [15:0] e, input logic [1:0] el,
                                 input logic w, input logic wr, input ctl_t k);
        bit prim = (e == 16'hC100);
        bit alt  = (e == 16'hE900);
        bit gate = w && k.el3_present && !k.el3_wide;
        int gated = k.sdd_undef ? 0 : 2;
        if (!prim && !alt) return 0;
        if (el == 0) return 0;
        if (alt) begin
            if (el == 1) return (k.nv == 3'b101) ? 3 : (k.nv[0] ? 1 : 0);
            if (el == 3) return k.host ? 5 : 0;
            if (gate && k.undef_first) return 0;
            if (!k.host) return 0;
            return gate ? gated : 5;
        end
        if (el == 3) return 5;
        if (gate && k.undef_first) return 0;
        if (el == 2) return gate ? gated : (k.host ? 4 : 5);
        if (k.el2_en && (wr ? k.vm_wr : k.vm_rd)) return 1;
        if (k.el2_en && k.fg_present && (!k.el3_present || k.fg_allow) &&
            (wr ? k.fg_wr : k.fg_rd)) return 1;
        if (w && k.el2_en && !(k.xctl_en && k.xctl_wide)) return 1;
        if (gate) return gated;
        return (k.nv == 3'b111) ? 3 : 5;
    endfunction

    function automatic string tag_of(input logic [15:0] e, input logic [1:0] el, input logic w);
        if (e != 16'hC100 && e != 16'hE900) return "R1";
        if (el == 0) return "R2";
        if (e == 16'hE900) return (el == 1) ? "R7" : "R8";
        if (el == 1) return w ? "R5" : "R4";
        return "R6";
    endfunction

    task automatic issue(input logic [15:0] e, input logic [1:0] el, input logic w,
                         input logic wr, input logic [DW-1:0] d, input ctl_t k);
        int idx;
        logic [5:0] exp_code;
        logic [DW-1:0] exp_rd;
        @(negedge clk);
        req_valid = 1'b1; req_enc = e; req_el = el; req_wide = w;
        req_write = wr; req_wdata = d; c = k;
        #1;
        idx = model(e, el, w, wr, k);
        exp_code = 6'b1 << idx;
        check(tag_of(e, el, w), "outcome", {122'b0, out_code}, {122'b0, exp_code});
        check("R9", "class", {122'b0, out_class},
              (idx == 1 || idx == 2) ? (w ? 128'h14 : 128'h18) : 128'h0);
        check("R10", "offset", {116'b0, mem_off}, (idx == 3) ? 128'h200 : 128'h0);
        exp_rd = '0;
        if (idx == 5 && !wr) exp_rd = w ? shadow : {64'b0, shadow[63:0]};
        check("R11", "read data", rd_data, exp_rd);
        if (idx == 5 && wr) begin
            if (w) shadow = d;
            else   shadow[63:0] = d[63:0];
        end
    endtask

    function automatic logic [DW-1:0] rnd128();
        return {$urandom(), $urandom(), $urandom(), $urandom()};
    endfunction

    function automatic ctl_t open_ctl();
        ctl_t k = '0;
        k.xctl_en = 1; k.xctl_wide = 1; k.el3_wide = 1;
        return k;
    endfunction

    initial begin
        ctl_t k;
        logic [DW-1:0] pat;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #1;
        check("R3", "idle outcome", {122'b0, out_code}, '0);
        // R12 reset value seen through a wide read at level 3
        issue(16'hC100, 2'd3, 1, 0, '0, open_ctl());
        check("R12", "reset store", rd_data, '0);
        // R12 wide write then narrow write keeps the upper half
        pat = 128'hA5A5_0001_0002_0003_0004_0005_0006_0007;
        issue(16'hC100, 2'd3, 1, 1, pat, open_ctl());
        issue(16'hC100, 2'd3, 0, 1, 128'hFFFF_FFFF_FFFF_FFFF_1111_2222_3333_4444, open_ctl());
        issue(16'hC100, 2'd3, 1, 0, '0, open_ctl());
        check("R12", "narrow write keeps upper", rd_data,
              128'hA5A5_0001_0002_0003_1111_2222_3333_4444);
        // R12 trapped write must not change the store
        k = open_ctl(); k.el2_en = 1; k.vm_wr = 1;
        issue(16'hC100, 2'd1, 1, 1, '1, k);
        issue(16'hC100, 2'd3, 1, 0, '0, open_ctl());
        check("R12", "trapped write ignored", rd_data,
              128'hA5A5_0001_0002_0003_1111_2222_3333_4444);
        // R4 read trap bit used only for reads
        k = open_ctl(); k.el2_en = 1; k.vm_wr = 1;
        issue(16'hC100, 2'd1, 0, 0, '0, k);
        // R4 memory redirect at nv 111
        k = open_ctl(); k.nv = 3'b111;
        issue(16'hC100, 2'd1, 0, 0, '0, k);
        // R5 gated wide access: undef-first, then level-3 trap
        k = open_ctl(); k.el3_present = 1; k.el3_wide = 0; k.undef_first = 1;
        k.el2_en = 1; k.vm_rd = 1;
        issue(16'hC100, 2'd1, 1, 0, '0, k);
        k.undef_first = 0; k.vm_rd = 0;
        issue(16'hC100, 2'd1, 1, 0, '0, k);
        // R5 extended control disabled traps to level 2
        k = open_ctl(); k.el2_en = 1; k.xctl_wide = 0;
        issue(16'hC100, 2'd1, 1, 0, '0, k);
        // R6 host redirect at level 2
        k = open_ctl(); k.host = 1;
        issue(16'hC100, 2'd2, 0, 1, '1, k);
        // R7 alias nv decode
        k = open_ctl(); k.nv = 3'b101; issue(16'hE900, 2'd1, 0, 0, '0, k);
        k.nv = 3'b011; issue(16'hE900, 2'd1, 1, 0, '0, k);
        k.nv = 3'b110; issue(16'hE900, 2'd1, 0, 0, '0, k);
        // R8 alias without host is undefined
        k = open_ctl(); issue(16'hE900, 2'd3, 0, 0, '0, k);
        // R2 level 0
        issue(16'hE900, 2'd0, 1, 0, '0, open_ctl());
        // Random mix
        for (int i = 0; i < 4000; i++) begin
            logic [15:0] e;
            int sel = $urandom_range(0, 9);
            e = (sel < 5) ? 16'hC100 : (sel < 9) ? 16'hE900 : 16'($urandom());
            k = ctl_t'($urandom());
            if ($urandom_range(0, 3) == 0) k = open_ctl();
            issue(e, 2'($urandom()), 1'($urandom()), 1'($urandom()), rnd128(), k);
        end
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        check("R3", "idle after traffic", {122'b0, out_code}, '0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog R3 actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule